// File: doc/BRIEF.md
# Infrared SIR Pulse Encoder

This block sits between a UART transmitter and an infrared transceiver. It turns the UART's serial output into short light pulses. In normal SIR operation, each logic-zero bit becomes one pulse that lasts three sixteenths of the bit period. Logic-one bits stay dark. The bit period is taken from a 16x oversampling tick, the same tick that paces the UART.

A low-power mode is also provided. In this mode the pulse width is set by a separate low-power reference tick, so the width no longer depends on the baud rate. Each zero-bit pulse then lasts three periods of that reference tick.

The block is active only when both the UART enable and the SIR enable are high. While it is active, the ordinary TXD line is held at the marking level. While it is inactive, TXD simply follows the UART output and the infrared line stays dark. The mode bit is sampled once per bit, at the bit boundary, so switching modes never shortens a pulse that is already running.

Top module: `sir_pulse_encoder`

## Requirements
- R1: In normal mode (`lp_mode`=0 latched at the boundary), a zero bit drives `sir_out_n` low from the clock after the boundary tick until the clock after the 16x tick that has phase 3, which is three 16x tick intervals.
- R2: In low-power mode (`lp_mode`=1 latched at the boundary), a zero bit drives `sir_out_n` low from the clock after the boundary tick until the third `lp_tick` that follows the boundary cycle. The 16x tick has no effect on this width.
- R3: When `uart_en` or `sir_en` is 0, `sir_out_n` is 1 and `txd` equals `tx_bit` in the same cycle. `sir_en` has no effect while `uart_en` is 0.
- R4: When both `uart_en` and `sir_en` are 1, `txd` is 1.
- R5: A bit sampled as 1 produces no pulse: `sir_out_n` stays 1 for the whole of that bit.
- R6: After the block becomes active, its first 16x tick is a bit boundary, and so is every 16th tick after it. `tx_bit` is sampled only in boundary cycles.
- R7: `lp_mode` is sampled only at a bit boundary. A change in the middle of a bit takes effect at the next boundary.
- R8: While `rst_n` is 0, `sir_out_n` is 1 whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud16_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| lp_tick | input | 1 | One-cycle strobe from the low-power reference |
| uart_en | input | 1 | UART enable |
| sir_en | input | 1 | Infrared mode enable |
| lp_mode | input | 1 | 1 selects the fixed low-power pulse width |
| tx_bit | input | 1 | Raw serial bit from the UART transmitter |
| sir_out_n | output | 1 | Infrared drive, 0 means light on |
| txd | output | 1 | Gated ordinary transmit line |

## Verification
The assertions assume four things about the inputs. `baud16_tick` and `lp_tick` are single-cycle strobes. `tx_bit` is stable whenever a boundary tick can occur. Bit boundaries are counted from the cycle in which the block becomes active.

The stimulus meets these assumptions by construction. It generates both ticks as periodic one-cycle strobes with unequal periods, and it changes `tx_bit` only between boundary ticks. It drops the enables whenever it starts a new configuration, so the phase count restarts from zero.

One of the low-power reference periods is long enough that a pulse runs past the next boundary. This exercises the rule that a boundary restarts the pulse state.

// File: rtl/sir_pkg.sv
// Shared types for the infrared pulse encoder.
// Assumes nothing beyond a single clock domain.
package sir_pkg;
    typedef enum logic {
        SIR_NORMAL = 1'b0,
        SIR_LOWPWR = 1'b1
    } sir_mode_e;
endpackage

// File: rtl/sir_phase_counter.sv
// Counts 16x ticks within a bit period and flags the bit boundary.
// Assumes tick is a one-cycle strobe; the count restarts whenever the
// encoder is inactive, so the first tick after activation is a boundary.
module sir_phase_counter #(
    parameter int OVERSAMPLE = 16,
    localparam int PH_W      = $clog2(OVERSAMPLE)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  logic            tick,
    output logic [PH_W-1:0] phase,
    output logic            boundary
);
    // A boundary is a tick taken at phase zero while active.
    assign boundary = active && tick && (phase == '0);

    // Advance the phase on every tick, wrapping at OVERSAMPLE.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            phase <= '0;
        end else if (tick) begin
            if (phase == PH_W'(OVERSAMPLE - 1)) phase <= '0;
            else                                phase <= phase + 1'b1;
        end
    end

    // R6: every active tick moves the phase on by one position.
    assert_phase_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && tick) |=> (phase == PH_W'(($past(phase) + 1) % OVERSAMPLE)));
endmodule

// File: rtl/sir_pulse_timer.sv
// Holds the light-on state for the current bit. It starts a pulse at a
// boundary when the sampled bit is zero and ends it after NORM_WIDTH 16x
// ticks or LP_WIDTH low-power ticks, depending on the mode latched at that
// boundary. Assumes both ticks are one-cycle strobes.
module sir_pulse_timer
    import sir_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int NORM_WIDTH = 3,
    parameter int LP_WIDTH   = 3,
    localparam int PH_W      = $clog2(OVERSAMPLE),
    localparam int LP_W      = $clog2(LP_WIDTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  logic            tick,
    input  logic            lp_tick,
    input  logic            boundary,
    input  logic [PH_W-1:0] phase,
    input  logic            tx_bit,
    input  logic            lp_mode,
    output logic            light
);
    sir_mode_e       mode_q;
    logic [LP_W-1:0] lp_left;

    // Start, time and end each pulse; clear everything while inactive.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            light   <= 1'b0;
            mode_q  <= SIR_NORMAL;
            lp_left <= '0;
        end else if (boundary) begin
            light   <= ~tx_bit;
            mode_q  <= sir_mode_e'(lp_mode);
            lp_left <= LP_W'(LP_WIDTH);
        end else begin
            if (mode_q == SIR_NORMAL && tick && phase == PH_W'(NORM_WIDTH))
                light <= 1'b0;
            if (mode_q == SIR_LOWPWR && lp_tick && lp_left != '0) begin
                lp_left <= lp_left - 1'b1;
                if (lp_left == LP_W'(1)) light <= 1'b0;
            end
        end
    end

    // R1: a normal-mode pulse lives only in phases 1..NORM_WIDTH.
    assert_norm_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (light && mode_q == SIR_NORMAL) |-> (phase != '0 && phase <= PH_W'(NORM_WIDTH)));
    // R3: an inactive encoder is dark on the next cycle.
    assert_dark_inactive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !light);
    // R5: a one sampled at a boundary gives no light.
    assert_one_dark_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && tx_bit) |=> !light);
    // R6: light only ever turns on right after a boundary.
    assert_start_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(light) |-> $past(boundary));
    // R7: the latched mode holds between boundaries.
    assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !boundary) |=> $stable(mode_q));
endmodule

// File: rtl/sir_pulse_encoder.sv
// Top of the infrared pulse encoder. It combines the enables, counts bit
// phase, times pulses and drives the active-low light output and the
// gated TXD line. Assumes ticks are one-cycle strobes in the clk domain.
module sir_pulse_encoder #(
    parameter int OVERSAMPLE = 16,
    parameter int NORM_WIDTH = 3,
    parameter int LP_WIDTH   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic baud16_tick,
    input  logic lp_tick,
    input  logic uart_en,
    input  logic sir_en,
    input  logic lp_mode,
    input  logic tx_bit,
    output logic sir_out_n,
    output logic txd
);
    localparam int PH_W = $clog2(OVERSAMPLE);

    logic            active;
    logic [PH_W-1:0] phase;
    logic            boundary;
    logic            light;

    // SIR enable only counts while the UART itself is enabled.
    assign active = uart_en && sir_en;

    sir_phase_counter #(.OVERSAMPLE(OVERSAMPLE)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .tick     (baud16_tick),
        .phase    (phase),
        .boundary (boundary)
    );

    sir_pulse_timer #(
        .OVERSAMPLE (OVERSAMPLE),
        .NORM_WIDTH (NORM_WIDTH),
        .LP_WIDTH   (LP_WIDTH)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .tick     (baud16_tick),
        .lp_tick  (lp_tick),
        .boundary (boundary),
        .phase    (phase),
        .tx_bit   (tx_bit),
        .lp_mode  (lp_mode),
        .light    (light)
    );

    // Drive light as a low level; mark TXD while infrared owns the line.
    assign sir_out_n = ~(light && active && rst_n);
    assign txd       = active ? 1'b1 : tx_bit;

    // R4: TXD is at marking whenever the encoder is active.
    assert_txd_mark_R4: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> txd);
    // R3: the pin is dark whenever the encoder is inactive.
    assert_pin_dark_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> sir_out_n);
endmodule

// File: tb/sir_pulse_encoder_tb.sv
module sir_pulse_encoder_tb;
    localparam int TP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic baud16_tick = 1'b0, lp_tick = 1'b0;
    logic uart_en = 1'b0, sir_en = 1'b0, lp_mode = 1'b0, tx_bit = 1'b1;
    logic sir_out_n, txd;

    int checks = 0, errors = 0, cyc = 0, lpp = 5;
    int tc = 0, lpc = 3;
    bit on = 0, cur_lp = 0, cur_zero = 0, flip_run = 0, done = 0;
    logic [4:0] pat = 5'b10010;

    always #2.5 clk = ~clk;

    sir_pulse_encoder u_dut (
        .clk(clk), .rst_n(rst_n), .baud16_tick(baud16_tick), .lp_tick(lp_tick),
        .uart_en(uart_en), .sir_en(sir_en), .lp_mode(lp_mode), .tx_bit(tx_bit),
        .sir_out_n(sir_out_n), .txd(txd)
    );

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // One clock: drive inputs, update the expected model, compare at negedge.
    task automatic step();
        bit a, bnd;
        string tag;
        a = uart_en && sir_en;
        baud16_tick = ((cyc % TP) == TP - 1);
        lp_tick     = ((cyc % lpp) == lpp - 1);
        if (a) begin
            if (flip_run && (tc % 16) == 1) lp_mode = ((tc / 16) % 2) == 1;
            if ((tc % 16) == 0) tx_bit = pat[(tc / 16) % 5];
        end else begin
            tx_bit = cyc[3];
        end
        @(posedge clk);
        if (!a) begin
            tc = 0; on = 0; cur_lp = 0; lpc = 3;
        end else begin
            bnd = baud16_tick && ((tc % 16) == 0);
            if (bnd) begin
                on = !tx_bit; cur_zero = !tx_bit; cur_lp = lp_mode; lpc = 0;
            end else begin
                if (!cur_lp && baud16_tick && (tc % 16) == 3) on = 0;
                if (cur_lp && lp_tick && lpc < 3) begin
                    lpc++;
                    if (lpc == 3) on = 0;
                end
            end
            if (baud16_tick) tc++;
        end
        cyc++;
        @(negedge clk);
        if (!a)                 tag = "R3";
        else if (flip_run)      tag = "R7";
        else if (tc <= 16)      tag = "R6";
        else if (!cur_zero)     tag = "R5";
        else if (cur_lp)        tag = "R2";
        else                    tag = "R1";
        check(tag, sir_out_n, !(on && a));
        check(a ? "R4" : "R3", txd, a ? 1'b1 : tx_bit);
    endtask

    task automatic run(bit u, bit s, bit m, int lperiod, bit flip, logic [4:0] p);
        lpp = lperiod; flip_run = flip; pat = p;
        uart_en = 1'b0; sir_en = 1'b0;
        for (int i = 0; i < 8; i++) step();
        uart_en = u; sir_en = s; lp_mode = m;
        for (int i = 0; i < 5 * 16 * TP + 6; i++) step();
        flip_run = 0;
    endtask

    initial begin
        @(negedge clk);
        // R8: reset holds the pin dark even with everything enabled
        uart_en = 1'b1; sir_en = 1'b1; tx_bit = 1'b0;
        for (int i = 0; i < 6; i++) begin
            baud16_tick = (i % 2 == 0);
            @(negedge clk);
            check("R8", sir_out_n, 1'b1);
        end
        uart_en = 1'b0; sir_en = 1'b0; baud16_tick = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int lp = 0; lp < 3; lp++) begin
            for (int c = 0; c < 8; c++) begin
                run(c[2], c[1], c[0], (lp == 0) ? 5 : ((lp == 1) ? 7 : 23), 1'b0, 5'b10010);
            end
        end
        run(1'b1, 1'b1, 1'b0, 5, 1'b1, 5'b00000);
        run(1'b1, 1'b1, 1'b1, 7, 1'b1, 5'b00000);
        run(1'b1, 1'b1, 1'b0, 5, 1'b0, 5'b11111);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule